// File: doc/BRIEF.md
# Selectable Frequency / Alarm Interrupt Output

This block drives one push-pull output pin that serves either as a clock-rate output or as an active-low alarm interrupt. A two-bit select field picks the function. The pin can carry the raw timebase, a derived 100 Hz square wave, a derived 1 Hz square wave, or the interrupt and idle function. In the interrupt and idle function, the pin rests high and is pulled low while an alarm is pending.

The timebase arrives as a 32.768 kHz square wave that is already synchronous to the system clock. The block finds its rising edges and treats each one as a timebase tick. The 100 Hz rate comes from a phase accumulator that adds the target rate on every tick and wraps at the timebase rate, so no integer divider is needed. The 1 Hz rate comes from a tick counter that toggles a flag every half second.

An alarm pulse latches a pending flag, and the flag holds until the host sends an acknowledge strobe. A new select value is only taken into use on a timebase tick, so switching modes never cuts a half period short between ticks.

Top module: `fio_out_select`

## Requirements
- R1: After a synchronous reset the pin is high, the applied select is 00, the accumulator and the half-second counter are zero, the slow square wave is low, and no alarm is pending.
- R2: With applied select 00 and no alarm pending, the pin is high (inactive).
- R3: An alarm pulse sets the pending flag on the next clock edge. With select 00 the pin goes low one edge later and stays low until an acknowledge.
- R4: An acknowledge strobe clears the pending flag and the pin returns high. If alarm and acknowledge arrive in the same cycle, the alarm wins and the flag stays set.
- R5: The pending flag is latched whatever the select is. A pending alarm shows on the pin as soon as select 00 is applied.
- R6: With select 01 the pin follows the timebase wave, delayed by two clock edges.
- R7: With select 10 the accumulator adds MID_HZ per tick modulo TB_HZ. The pin is high when the accumulator is at least TB_HZ/2, so after n ticks the pin is ((n*MID_HZ) mod TB_HZ) >= TB_HZ/2.
- R8: With select 11 the pin is a square wave that inverts every TB_HZ/2 ticks, starting low after reset, so after n ticks it equals (n / (TB_HZ/2)) mod 2.
- R9: A change on the select input is taken into use only on the next timebase tick. Until then the pin keeps the function of the previous select.
- R10: A tick is produced once per rising edge of the timebase wave, and never on two clock cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_wave | input | 1 | Timebase square wave, synchronous to clk |
| sel_field | input | 2 | Function select: 00 interrupt/idle, 01 timebase, 10 100 Hz, 11 1 Hz |
| alarm_evt | input | 1 | One-cycle alarm event pulse |
| irq_ack | input | 1 | One-cycle host acknowledge strobe |
| fio_pin | output | 1 | Push-pull output level |

## Verification
The assertions assume that the timebase wave is already in the clock domain and is much slower than the clock. They also assume that alarm and acknowledge are single-cycle strobes. The bench keeps to this by holding each phase of the wave for four clocks and driving every input on the falling clock edge. The bench uses a small configuration with a 64 Hz timebase and a 5 Hz mid rate, which makes the accumulator wrap with a remainder. It sweeps every mode over many ticks, and each sample is compared against the closed-form tick-count formulas.

// File: rtl/fio_pkg.sv
package fio_pkg;

    typedef enum logic [1:0] {
        MODE_IRQ  = 2'b00,
        MODE_FAST = 2'b01,
        MODE_MID  = 2'b10,
        MODE_SLOW = 2'b11
    } fio_mode_e;

    typedef struct packed {
        logic fast;
        logic mid;
        logic slow;
    } fio_srcs_t;

    function automatic logic fio_pick(input fio_mode_e mode,
                                      input fio_srcs_t srcs,
                                      input logic      pend);
        logic r;
        case (mode)
            MODE_FAST: r = srcs.fast;
            MODE_MID:  r = srcs.mid;
            MODE_SLOW: r = srcs.slow;
            default:   r = ~pend;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fio_tick_edge.sv
module fio_tick_edge (
    input  logic clk,
    input  logic rst,
    input  logic wave_in,
    output logic wave_q,
    output logic tick
);
    logic wave_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
            wave_d <= 1'b0;
        end else begin
            wave_q <= wave_in;
            wave_d <= wave_q;
        end
    end

    assign tick = wave_q & ~wave_d;

    a_r10_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/fio_rate_gen.sv
module fio_rate_gen #(
    parameter int TB_HZ  = 32768,
    parameter int MID_HZ = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic mid_out,
    output logic slow_out
);
    localparam int ACC_W  = $clog2(TB_HZ);
    localparam int HALF   = TB_HZ / 2;
    localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;
    logic [ACC_W-1:0] acc_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             slow_q;

    always_comb begin
        acc_sum = {1'b0, acc_q} + (ACC_W+1)'(MID_HZ);
        if (acc_sum >= (ACC_W+1)'(TB_HZ))
            acc_nxt = ACC_W'(acc_sum - (ACC_W+1)'(TB_HZ));
        else
            acc_nxt = acc_sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (tick) begin
            acc_q <= acc_nxt;
            if (cnt_q == CNT_W'(HALF - 1)) begin
                cnt_q  <= '0;
                slow_q <= ~slow_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mid_out  = ({1'b0, acc_q} >= (ACC_W+1)'(HALF));
    assign slow_out = slow_q;

    a_r7_acc_still: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(acc_q));
    a_r8_slow_still: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slow_q));

endmodule

// File: rtl/fio_irq_latch.sv
module fio_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic alarm,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)        pend <= 1'b0;
        else if (alarm) pend <= 1'b1;
        else if (ack)   pend <= 1'b0;
    end

    a_r3_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);
    a_r4_alarm_wins: assert property (@(posedge clk) disable iff (rst)
        alarm |=> pend);

endmodule

// File: rtl/fio_out_select.sv
module fio_out_select
    import fio_pkg::*;
#(
    parameter int TB_HZ  = 32768,
    parameter int MID_HZ = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tb_wave,
    input  logic [1:0] sel_field,
    input  logic       alarm_evt,
    input  logic       irq_ack,
    output logic       fio_pin
);
    logic      wave_q;
    logic      tick;
    logic      pend;
    fio_srcs_t srcs;
    fio_mode_e mode_q;
    logic      pin_q;

    fio_tick_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .wave_in (tb_wave),
        .wave_q  (wave_q),
        .tick    (tick)
    );

    fio_rate_gen #(
        .TB_HZ  (TB_HZ),
        .MID_HZ (MID_HZ)
    ) u_rates (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mid_out  (srcs.mid),
        .slow_out (srcs.slow)
    );

    fio_irq_latch u_irq (
        .clk   (clk),
        .rst   (rst),
        .alarm (alarm_evt),
        .ack   (irq_ack),
        .pend  (pend)
    );

    assign srcs.fast = wave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IRQ;
            pin_q  <= 1'b1;
        end else begin
            if (tick) mode_q <= fio_mode_e'(sel_field);
            pin_q <= fio_pick(mode_q, srcs, pend);
        end
    end

    assign fio_pin = pin_q;

    a_r9_mode_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_q));
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IRQ && !pend) |=> fio_pin);
    a_r3_pin_low: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IRQ && pend) |=> !fio_pin);

endmodule

// File: tb/tb_fio_out_select.sv
module tb_fio_out_select;
    localparam int CLK_PERIOD = 10;
    localparam int TB   = 64;
    localparam int MID  = 5;
    localparam int HALF = TB / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_wave = 1'b0;
    logic [1:0] sel_field = 2'b00;
    logic       alarm_evt = 1'b0;
    logic       irq_ack = 1'b0;
    logic       fio_pin;

    int total = 0;
    int bad = 0;
    int n = 0;
    logic [1:0] cur_mode = 2'b00;
    logic [1:0] pend_mode = 2'b00;
    logic irq_exp = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fio_out_select #(.TB_HZ(TB), .MID_HZ(MID)) dut (
        .clk(clk), .rst(rst), .tb_wave(tb_wave), .sel_field(sel_field),
        .alarm_evt(alarm_evt), .irq_ack(irq_ack), .fio_pin(fio_pin)
    );

    function automatic logic exp_pin(input logic [1:0] m, input logic hi);
        case (m)
            2'b01:   return hi;
            2'b10:   return ((n * MID) % TB) >= HALF;
            2'b11:   return ((n / HALF) % 2) == 1;
            default: return !irq_exp;
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        total++;
        if (fio_pin !== exp) begin
            bad++;
            $display("FAIL %s: pin=%b expected=%b (ticks=%0d mode=%b)",
                     req, fio_pin, exp, n, cur_mode);
        end
    endtask

    function automatic string tag(input logic [1:0] m);
        case (m)
            2'b01:   return "R6";
            2'b10:   return "R7";
            2'b11:   return "R8";
            default: return "R2";
        endcase
    endfunction

    // One timebase period; each rising edge is one tick (R10).
    task automatic do_tick();
        tb_wave = 1'b1;
        n++;
        cur_mode = pend_mode;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tag(cur_mode), exp_pin(cur_mode, 1'b1));
        tb_wave = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tag(cur_mode), exp_pin(cur_mode, 1'b0));
    endtask

    // Change select mid low phase; old function must persist until tick (R9).
    task automatic set_mode(input logic [1:0] m);
        sel_field = m;
        pend_mode = m;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", exp_pin(cur_mode, 1'b0));
    endtask

    task automatic strobe(input logic a, input logic k);
        alarm_evt = a;
        irq_ack = k;
        @(negedge clk);
        alarm_evt = 1'b0;
        irq_ack = 1'b0;
        if (a) irq_exp = 1'b1;
        else if (k) irq_exp = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 1'b1);

        for (int i = 0; i < 3; i++) do_tick();

        set_mode(2'b10);
        for (int i = 0; i < 40; i++) do_tick();

        set_mode(2'b11);
        for (int i = 0; i < 80; i++) do_tick();

        set_mode(2'b01);
        for (int i = 0; i < 10; i++) do_tick();

        set_mode(2'b00);
        do_tick();
        strobe(1'b1, 1'b0);
        check("R3", 1'b0);
        do_tick();
        do_tick();
        check("R3", 1'b0);
        strobe(1'b0, 1'b1);
        check("R4", 1'b1);
        strobe(1'b1, 1'b1);
        check("R4", 1'b0);
        strobe(1'b0, 1'b1);
        check("R4", 1'b1);

        set_mode(2'b11);
        do_tick();
        strobe(1'b1, 1'b0);
        check("R5", exp_pin(2'b11, 1'b0));
        set_mode(2'b00);
        do_tick();
        check("R5", 1'b0);
        strobe(1'b0, 1'b1);
        check("R5", 1'b1);

        set_mode(2'b10);
        for (int i = 0; i < 20; i++) do_tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule